// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block derives the timing of a serial channel from the peripheral operating clock. It has three configuration inputs: an integer divisor, a fine adjustment and a coarse-ratio select. From them it produces an oversample tick and a once-per-bit strobe. Each bit is made of a fixed number of oversample slots, either sixteen or four. Every slot lasts (divisor + 1) clocks. The final slot of a bit is lengthened by the fine adjustment, so one bit takes slots × (divisor + 1) + fine clocks.

The configuration is captured at each bit boundary. A change written in the middle of a bit therefore takes effect only when the next bit begins. While the block is disabled, its configuration register follows the inputs.

The counters freeze without losing their place in two cases: a debug halt while running in debug is not allowed, and sleep while the sleep clock-stop control is set. When the freeze ends, counting resumes from the same point. Deasserting the enable clears all counting state.

Top module: `frac_baud_gen`

## Requirements
- R1: While running, oversample ticks inside a bit, other than the final one, are spaced exactly div_int + 1 counted clocks apart. The first tick falls on the (div_int + 1)-th counted clock of the bit.
- R2: bit_strobe is high for one counted clock per bit. It coincides with the bit's final os_tick. Successive strobes are slots × (div_int + 1) + fine_adj counted clocks apart.
- R3: coarse_fast = 0 gives 16 slots per bit. coarse_fast = 1 gives 4 slots per bit.
- R4: fine_adj (0 to 15) lengthens only the final slot of each bit, by fine_adj clocks.
- R5: A change of div_int, fine_adj or coarse_fast while enabled has no effect on the current bit. It applies from the bit that starts after the next bit_strobe.
- R6: While enable is low, both outputs are low and all counting state is cleared. The first bit after enable rises is a complete bit that starts at its beginning.
- R7: While halt_req = 1 and run_in_halt = 0, both outputs are low and no clock is counted. When the halt ends, timing continues from the clock where it stopped.
- R8: While halt_req = 1 and run_in_halt = 1, the generator runs exactly as it would without the halt.
- R9: While sleep_active = 1 and sleep_clk_stop = 1, the generator freezes as in R7. While sleep_active = 1 and sleep_clk_stop = 0, it keeps running.
- R10: While rst is high and enable is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral operating clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Generator enable; low clears the counters |
| div_int | input | 8 | Integer divisor; a slot lasts div_int + 1 clocks |
| fine_adj | input | 4 | Extra clocks added to the last slot of each bit |
| coarse_fast | input | 1 | 0: 16 slots per bit, 1: 4 slots per bit |
| halt_req | input | 1 | CPU is in debug halt |
| run_in_halt | input | 1 | 1: keep running during debug halt |
| sleep_active | input | 1 | System is in sleep |
| sleep_clk_stop | input | 1 | 1: operating clock is stopped during sleep |
| os_tick | output | 1 | One-clock oversample tick |
| bit_strobe | output | 1 | One-clock strobe at the end of each bit |

## Verification
The bench sweeps every fine adjustment against small divisors in both coarse ratios, and adds the largest divisor. A design that put the fine clocks into every slot, or into the first slot, would move the intermediate ticks. One that counted the divisor without its +1 would shorten each slot. Mid-bit configuration changes catch a design that reloads at once and emits a runt bit. Freezes placed mid-slot and exactly on a tick, for both debug and sleep, expose a design that loses or repeats a clock when it resumes. A re-enable after a disable exposes a stale slot or prescale count.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    localparam int DIV_W     = 8;
    localparam int FINE_W    = 4;
    localparam int SLOT_SLOW = 16;
    localparam int SLOT_FAST = 4;
    localparam int SLOT_W    = $clog2(SLOT_SLOW);
    localparam int PRE_W     = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [FINE_W-1:0] fine;
        logic              fast;
    } baud_cfg_t;

    function automatic logic [SLOT_W-1:0] last_slot_idx(input logic fast);
        return fast ? SLOT_W'(SLOT_FAST - 1) : SLOT_W'(SLOT_SLOW - 1);
    endfunction

    function automatic logic [PRE_W-1:0] slot_limit(input baud_cfg_t c, input logic is_last);
        logic [PRE_W-1:0] base;
        base = PRE_W'(c.div);
        return is_last ? base + PRE_W'(c.fine) : base;
    endfunction

endpackage

// File: rtl/baud_run_ctrl.sv
module baud_run_ctrl (
    input  logic enable,
    input  logic halt_req,
    input  logic run_in_halt,
    input  logic sleep_active,
    input  logic sleep_clk_stop,
    output logic run
);
    logic halt_freeze;
    logic sleep_freeze;

    always_comb begin
        halt_freeze  = halt_req && !run_in_halt;
        sleep_freeze = sleep_active && sleep_clk_stop;
        run          = enable && !halt_freeze && !sleep_freeze;
    end
endmodule

// File: rtl/baud_cfg_latch.sv
module baud_cfg_latch
    import frac_baud_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      bit_done,
    input  baud_cfg_t cfg_in,
    output baud_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (!enable || bit_done) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/baud_counter.sv
module baud_counter
    import frac_baud_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      run,
    input  baud_cfg_t cfg,
    output logic      os_tick,
    output logic      bit_strobe
);
    logic [PRE_W-1:0]  pre_cnt;
    logic [SLOT_W-1:0] slot_cnt;
    logic              in_last;
    logic              slot_end;
    logic [PRE_W-1:0]  limit;

    always_comb begin
        in_last    = (slot_cnt == last_slot_idx(cfg.fast));
        limit      = slot_limit(cfg, in_last);
        slot_end   = (pre_cnt == limit);
        os_tick    = run && slot_end;
        bit_strobe = os_tick && in_last;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pre_cnt  <= '0;
            slot_cnt <= '0;
        end else if (run) begin
            if (slot_end) begin
                pre_cnt  <= '0;
                slot_cnt <= in_last ? '0 : slot_cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    assert_bit_restart_R2: assert property (@(posedge clk) disable iff (rst)
        bit_strobe && enable |=> (pre_cnt == '0) && (slot_cnt == '0));

    assert_disable_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (pre_cnt == '0) && (slot_cnt == '0));

    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (rst)
        enable && !run && $past(enable) |=> $stable(pre_cnt) && $stable(slot_cnt));

    assert_slot_bound_R4: assert property (@(posedge clk) disable iff (rst)
        pre_cnt <= PRE_W'(cfg.div) + PRE_W'(cfg.fine));

    assert_slot_range_R3: assert property (@(posedge clk) disable iff (rst)
        slot_cnt <= last_slot_idx(cfg.fast));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div_int,
    input  logic [FINE_W-1:0] fine_adj,
    input  logic              coarse_fast,
    input  logic              halt_req,
    input  logic              run_in_halt,
    input  logic              sleep_active,
    input  logic              sleep_clk_stop,
    output logic              os_tick,
    output logic              bit_strobe
);
    baud_cfg_t cfg_in;
    baud_cfg_t cfg_q;
    logic      run;

    always_comb begin
        cfg_in.div  = div_int;
        cfg_in.fine = fine_adj;
        cfg_in.fast = coarse_fast;
    end

    baud_run_ctrl u_run (
        .enable         (enable),
        .halt_req       (halt_req),
        .run_in_halt    (run_in_halt),
        .sleep_active   (sleep_active),
        .sleep_clk_stop (sleep_clk_stop),
        .run            (run)
    );

    baud_cfg_latch u_cfg (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .bit_done (bit_strobe),
        .cfg_in   (cfg_in),
        .cfg_q    (cfg_q)
    );

    baud_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .run        (run),
        .cfg        (cfg_q),
        .os_tick    (os_tick),
        .bit_strobe (bit_strobe)
    );

    assert_quiet_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        !run |-> !os_tick && !bit_strobe);

    assert_halt_run_R8: assert property (@(posedge clk) disable iff (rst)
        enable && halt_req && run_in_halt && !(sleep_active && sleep_clk_stop) |-> run);

    assert_sleep_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        sleep_active && sleep_clk_stop |-> !os_tick && !bit_strobe);

    assert_strobe_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |-> os_tick);

    always_comb begin
        if (rst && !enable) begin
            assert_reset_quiet_R10: assert (!os_tick && !bit_strobe);
        end
    end
endmodule

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [7:0] div_int = '0;
    logic [3:0] fine_adj = '0;
    logic       coarse_fast = 1'b0;
    logic       halt_req = 1'b0;
    logic       run_in_halt = 1'b0;
    logic       sleep_active = 1'b0;
    logic       sleep_clk_stop = 1'b0;
    logic       os_tick;
    logic       bit_strobe;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;
    string tag = "R10";

    // bench model state: latched config and position within the bit
    int m_div = 0, m_fine = 0, m_pos = 0;
    bit m_fast = 0;

    always #2.5 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk(clk), .rst(rst), .enable(enable), .div_int(div_int),
        .fine_adj(fine_adj), .coarse_fast(coarse_fast), .halt_req(halt_req),
        .run_in_halt(run_in_halt), .sleep_active(sleep_active),
        .sleep_clk_stop(sleep_clk_stop), .os_tick(os_tick), .bit_strobe(bit_strobe)
    );

    task automatic check(string req, string what, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // called right after a negedge with inputs already set
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            bit going, e_tick, e_strobe;
            int slots, sl, per;
            #1;
            going = enable && !(halt_req && !run_in_halt) && !(sleep_active && sleep_clk_stop);
            slots = m_fast ? 4 : 16;
            sl    = m_div + 1;
            per   = slots * sl + m_fine;
            e_strobe = going && (m_pos == per - 1);
            e_tick   = going && (e_strobe ||
                       (((m_pos + 1) % sl == 0) && (m_pos + 1 <= (slots - 1) * sl)));
            check(tag, "os_tick", os_tick, e_tick);
            check(tag, "bit_strobe", bit_strobe, e_strobe);
            if (!enable || rst) begin
                m_pos = 0;
                m_div = div_int; m_fine = fine_adj; m_fast = coarse_fast;
                if (rst) begin m_div = 0; m_fine = 0; m_fast = 0; end
            end else if (going) begin
                if (e_strobe) begin
                    m_pos = 0;
                    m_div = div_int; m_fine = fine_adj; m_fast = coarse_fast;
                end else begin
                    m_pos++;
                end
            end
            @(negedge clk);
        end
    endtask

    task automatic run_to_strobe(int limit);
        for (int i = 0; i < limit; i++) begin
            #1;
            if (bit_strobe) begin #1; return; end
            #0;
            step(1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tag = "R10 reset";
        step(4);
        rst = 1'b0;
        step(2);

        // R1/R2/R3/R4 sweep: every fine value, small divisors, both ratios
        tag = "R1/R2/R3/R4 sweep";
        for (int f = 0; f < 2; f++) begin
            for (int d = 0; d < 6; d++) begin
                for (int fn = 0; fn < 16; fn++) begin
                    enable = 1'b0;
                    div_int = 8'(d); fine_adj = 4'(fn); coarse_fast = f[0];
                    step(1);
                    enable = 1'b1;
                    step((f ? 4 : 16) * (d + 1) * 2 + 2 * fn + 1);
                end
            end
        end

        tag = "R1/R2 max divisor";
        enable = 1'b0; div_int = 8'd255; fine_adj = 4'd15; coarse_fast = 1'b0;
        step(1);
        enable = 1'b1;
        step(16 * 256 + 15 + 10);

        // R5: change configuration mid-bit
        tag = "R5 mid-bit change";
        enable = 1'b0; div_int = 8'd3; fine_adj = 4'd2; coarse_fast = 1'b0;
        step(1);
        enable = 1'b1;
        step(20);
        div_int = 8'd1; fine_adj = 4'd5; coarse_fast = 1'b1;
        step(200);
        div_int = 8'd2; fine_adj = 4'd0; coarse_fast = 1'b0;
        step(7);
        fine_adj = 4'd9;
        step(150);

        // R6: disable mid-bit and re-enable
        tag = "R6 disable";
        enable = 1'b0;
        step(5);
        enable = 1'b1;
        step(60);

        // R7: debug halt freezes, mid-slot and on a tick
        tag = "R7 halt freeze";
        div_int = 8'd2; fine_adj = 4'd3;
        halt_req = 1'b1; run_in_halt = 1'b0;
        step(9);
        halt_req = 1'b0;
        step(4);
        halt_req = 1'b1;
        step(3);
        halt_req = 1'b0;
        step(100);

        // R8: halt with run allowed
        tag = "R8 run in halt";
        halt_req = 1'b1; run_in_halt = 1'b1;
        step(120);
        halt_req = 1'b0; run_in_halt = 1'b0;

        // R9: sleep with and without clock stop
        tag = "R9 sleep stop";
        sleep_active = 1'b1; sleep_clk_stop = 1'b1;
        step(11);
        sleep_clk_stop = 1'b0;
        tag = "R9 sleep keep";
        step(80);
        sleep_active = 1'b0;
        step(40);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule